// File: doc/BRIEF.md
# Host-to-ISA Memory Window Decoder

This block classifies each memory cycle of a 32-bit host bus that carries address bits 31 down to 3 and eight active-low byte enables. Every cycle goes to exactly one destination: system memory, the 24-bit ISA memory bus, a firmware ROM select, or nowhere (a decode miss). ISA cycles receive a 24-bit ISA address whose three low bits are taken from the byte enables. They also receive active-low read or write strobes in two kinds. The full-range pair covers all 16 MB. The low pair is qualified for the first megabyte only.

Two host regions reach the ISA bus. The first is the legacy hole between 640 KB and 1 MB, which passes through unchanged. The second is a 384 KB window at the very top of the 4 GB host space. That window is folded down into the top of the 16 MB ISA space by checking that the host address bits above bit 23, which ISA does not carry, are all ones. A one-clock start pulse opens a cycle and the decode result is registered on that edge. The result is held until an end pulse closes the cycle.

Top module: `isa_window_decoder`

## Requirements
- R1: Host addresses 0000_0000h–0009_FFFFh and 0010_0000h–07FF_FFFFh assert mem_sel and leave all four strobes high and isa_addr at zero.
- R2: Host addresses 000A_0000h–000F_FFFFh go to ISA with isa_addr equal to the host address. Both the full-range and the low strobe of the cycle's direction go low.
- R3: Host addresses FFF8_0000h–FFFD_FFFFh go to ISA with isa_addr = host address bits 23:0 (00F8_0000h–00FD_FFFFh). Only the full-range strobe goes low and the low strobes stay high.
- R4: The high window and the ROM region require host bits 31:24 all ones. With any of those bits zero, an address whose lower 24 bits fall in a window decodes as a miss (above 07FF_FFFFh) or as system memory (below it).
- R5: Host addresses FFFE_0000h–FFFF_FFFFh assert rom_sel with no strobe and isa_addr zero.
- R6: Host addresses 0800_0000h–FFF7_FFFFh not covered above assert decode_miss with no strobe and isa_addr zero.
- R7: isa_addr[2:0] is the index of the lowest-numbered active byte enable, where host_be_n[i] low means byte i is enabled.
- R8: The outputs take the decoded values at the first rising edge that samples cyc_start high while no cycle is open. They hold until the rising edge that samples cyc_end high. That edge returns every output to its idle value. A start and an end sampled at the same edge while idle open a cycle.
- R9: A cyc_start sampled while a cycle is open is ignored, and the outputs keep their values.
- R10: A cyc_start with all eight byte enables high is ignored, and the outputs stay idle.
- R11: Idle values are strobes high, mem_sel, rom_sel and decode_miss low, and isa_addr zero. rst_n low at a rising edge forces them.
- R12: host_wr high selects the write strobes and host_wr low selects the read strobes. A read strobe and a write strobe are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_start | input | 1 | One-clock pulse that opens a host memory cycle |
| cyc_end | input | 1 | One-clock pulse that closes the open cycle |
| host_addr | input | 29 | Host address bits 31:3 |
| host_be_n | input | 8 | Active-low byte enables, bit i for byte i |
| host_wr | input | 1 | 1 = write cycle, 0 = read cycle |
| isa_addr | output | 24 | ISA memory address, zero unless the target is ISA |
| full_rd_n | output | 1 | Full 16 MB read strobe, active low |
| full_wr_n | output | 1 | Full 16 MB write strobe, active low |
| low_rd_n | output | 1 | First-megabyte read strobe, active low |
| low_wr_n | output | 1 | First-megabyte write strobe, active low |
| mem_sel | output | 1 | Cycle belongs to system memory |
| rom_sel | output | 1 | Cycle belongs to the firmware ROM region |
| decode_miss | output | 1 | Cycle has no target |

## Verification
The hardest case to reach from the ports is an address whose low 24 bits sit inside the high window while its upper byte is not all ones. Such an address looks like an ISA address to any logic that ignores bits 31:24. The table drives FEF8_0000h, 7FF8_0000h and 00FA_0000h, and expects a miss, a miss and system memory. The other hard cases are the protocol ones: a second start inside an open cycle, a start with no byte enables, and a start and end at the same edge. Directed sequences time these to exact edges and check the held outputs between them.

// File: rtl/isa_dec_pkg.sv
// Package: shared widths, region bounds and target type for the ISA window decoder.
// Assumes a byte-addressed host bus with eight byte lanes.
package isa_dec_pkg;
    localparam int HOST_AW = 32;
    localparam int ISA_AW  = 24;
    localparam int LOW_AW  = 20;
    localparam int BE_W    = 8;
    localparam int BYTE_AW = $clog2(BE_W);

    // Host-side boundaries (exclusive ends) of the low regions
    localparam logic [HOST_AW-1:0] MAIN_LO_END = 32'h000A_0000;
    localparam logic [HOST_AW-1:0] LEGACY_END  = 32'h0010_0000;
    localparam logic [HOST_AW-1:0] MAIN_HI_END = 32'h0800_0000;
    // Offsets inside the top 16 MB of host space
    localparam logic [ISA_AW-1:0]  HIWIN_BASE  = 24'hF8_0000;
    localparam logic [ISA_AW-1:0]  ROM_BASE    = 24'hFE_0000;

    typedef enum logic [1:0] {
        TGT_MAIN = 2'd0,
        TGT_ISA  = 2'd1,
        TGT_ROM  = 2'd2,
        TGT_NONE = 2'd3
    } tgt_e;
endpackage

// File: rtl/isa_be_encoder.sv
// Module: turns active-low byte enables into the byte offset of the lowest
// enabled lane, plus a flag that says whether any lane is enabled.
// Assumes BYTE_AW is wide enough to index BE_W lanes.
module isa_be_encoder #(
    parameter int BE_W    = 8,
    parameter int BYTE_AW = 3
) (
    input  logic [BE_W-1:0]    be_n,
    output logic [BYTE_AW-1:0] byte_off,
    output logic               any_en
);
    // Priority scan: the lowest enabled lane wins because it is written last.
    always_comb begin
        byte_off = '0;
        for (int i = BE_W - 1; i >= 0; i--) begin
            if (!be_n[i]) byte_off = BYTE_AW'(i);
        end
    end

    // A cycle counts only if at least one lane is enabled.
    assign any_en = ~&be_n;
endmodule

// File: rtl/isa_region_decode.sv
// Module: combinational address map. It classifies a host address (without
// byte bits) and forms the upper ISA address bits for ISA targets.
// Assumes HOST_AW > ISA_AW > LOW_AW > BYTE_AW.
module isa_region_decode
    import isa_dec_pkg::*;
#(
    parameter int HA_W  = 32,
    parameter int IA_W  = 24,
    parameter int LA_W  = 20,
    parameter int BA_W  = 3
) (
    input  logic [HA_W-1:BA_W] addr_hi,
    output tgt_e               tgt,
    output logic [IA_W-1:BA_W] isa_hi,
    output logic               low_mb
);
    logic [HA_W-1:0] full;
    logic            top_ok;
    logic            in_main;
    logic            in_legacy;
    logic            in_hiwin;
    logic            in_rom;

    assign full = {addr_hi, {BA_W{1'b0}}};

    // Region membership tests; the upper-byte check guards both top regions.
    always_comb begin
        top_ok    = &full[HA_W-1:IA_W];
        in_main   = (full < HA_W'(MAIN_LO_END)) ||
                    ((full >= HA_W'(LEGACY_END)) && (full < HA_W'(MAIN_HI_END)));
        in_legacy = (full >= HA_W'(MAIN_LO_END)) && (full < HA_W'(LEGACY_END));
        in_hiwin  = top_ok && (full[IA_W-1:0] >= IA_W'(HIWIN_BASE)) &&
                    (full[IA_W-1:0] < IA_W'(ROM_BASE));
        in_rom    = top_ok && (full[IA_W-1:0] >= IA_W'(ROM_BASE));
    end

    // Select the one target and build the ISA-side address.
    always_comb begin
        tgt    = TGT_NONE;
        isa_hi = '0;
        if (in_main) begin
            tgt = TGT_MAIN;
        end else if (in_legacy || in_hiwin) begin
            tgt    = TGT_ISA;
            isa_hi = full[IA_W-1:BA_W];
        end else if (in_rom) begin
            tgt = TGT_ROM;
        end
        low_mb = (tgt == TGT_ISA) && ~|isa_hi[IA_W-1:LA_W];
    end
endmodule

// File: rtl/isa_cycle_regs.sv
// Module: output register stage. It loads a decode result when an idle cycle
// starts, holds it until the end pulse, and then returns to idle.
// Assumes the decode inputs are stable in the clock where cyc_start is high.
module isa_cycle_regs
    import isa_dec_pkg::*;
#(
    parameter int IA_W = 24,
    parameter int BA_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cyc_start,
    input  logic               cyc_end,
    input  logic               be_any,
    input  logic               wr,
    input  tgt_e               tgt,
    input  logic [IA_W-1:BA_W] isa_hi,
    input  logic [BA_W-1:0]    byte_off,
    input  logic               low_mb,
    output logic [IA_W-1:0]    isa_addr,
    output logic               full_rd_n,
    output logic               full_wr_n,
    output logic               low_rd_n,
    output logic               low_wr_n,
    output logic               mem_sel,
    output logic               rom_sel,
    output logic               decode_miss
);
    logic            busy;
    logic            is_isa;
    logic [IA_W-1:0] nxt_addr;

    // Next-value terms for a cycle that is being opened.
    always_comb begin
        is_isa   = (tgt == TGT_ISA);
        nxt_addr = is_isa ? {isa_hi, byte_off} : '0;
    end

    // Cycle state: reset or end clears; an idle start with lanes loads.
    always_ff @(posedge clk) begin
        if (!rst_n || (busy && cyc_end)) begin
            busy        <= 1'b0;
            isa_addr    <= '0;
            full_rd_n   <= 1'b1;
            full_wr_n   <= 1'b1;
            low_rd_n    <= 1'b1;
            low_wr_n    <= 1'b1;
            mem_sel     <= 1'b0;
            rom_sel     <= 1'b0;
            decode_miss <= 1'b0;
        end else if (!busy && cyc_start && be_any) begin
            busy        <= 1'b1;
            isa_addr    <= nxt_addr;
            full_rd_n   <= !(is_isa && !wr);
            full_wr_n   <= !(is_isa && wr);
            low_rd_n    <= !(is_isa && low_mb && !wr);
            low_wr_n    <= !(is_isa && low_mb && wr);
            mem_sel     <= (tgt == TGT_MAIN);
            rom_sel     <= (tgt == TGT_ROM);
            decode_miss <= (tgt == TGT_NONE);
        end
    end
endmodule

// File: rtl/isa_window_decoder.sv
// Module: top of the host-to-ISA memory window decoder. It joins the
// byte-lane encoder, the region decoder and the registered output stage.
// Assumes host_addr and host_be_n are valid while cyc_start is high.
module isa_window_decoder
    import isa_dec_pkg::*;
#(
    parameter int HA_W = isa_dec_pkg::HOST_AW,
    parameter int IA_W = isa_dec_pkg::ISA_AW,
    parameter int LA_W = isa_dec_pkg::LOW_AW,
    parameter int BE_N = isa_dec_pkg::BE_W,
    localparam int BA_W = $clog2(BE_N)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cyc_start,
    input  logic               cyc_end,
    input  logic [HA_W-1:BA_W] host_addr,
    input  logic [BE_N-1:0]    host_be_n,
    input  logic               host_wr,
    output logic [IA_W-1:0]    isa_addr,
    output logic               full_rd_n,
    output logic               full_wr_n,
    output logic               low_rd_n,
    output logic               low_wr_n,
    output logic               mem_sel,
    output logic               rom_sel,
    output logic               decode_miss
);
    logic [BA_W-1:0]    byte_off;
    logic               be_any;
    tgt_e               tgt;
    logic [IA_W-1:BA_W] isa_hi;
    logic               low_mb;

    isa_be_encoder #(.BE_W(BE_N), .BYTE_AW(BA_W)) u_be (
        .be_n     (host_be_n),
        .byte_off (byte_off),
        .any_en   (be_any)
    );

    isa_region_decode #(.HA_W(HA_W), .IA_W(IA_W), .LA_W(LA_W), .BA_W(BA_W)) u_map (
        .addr_hi (host_addr),
        .tgt     (tgt),
        .isa_hi  (isa_hi),
        .low_mb  (low_mb)
    );

    isa_cycle_regs #(.IA_W(IA_W), .BA_W(BA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc_start   (cyc_start),
        .cyc_end     (cyc_end),
        .be_any      (be_any),
        .wr          (host_wr),
        .tgt         (tgt),
        .isa_hi      (isa_hi),
        .byte_off    (byte_off),
        .low_mb      (low_mb),
        .isa_addr    (isa_addr),
        .full_rd_n   (full_rd_n),
        .full_wr_n   (full_wr_n),
        .low_rd_n    (low_rd_n),
        .low_wr_n    (low_wr_n),
        .mem_sel     (mem_sel),
        .rom_sel     (rom_sel),
        .decode_miss (decode_miss)
    );
endmodule

// File: rtl/isa_window_decoder_chk.sv
// Module: assertion checker bound to isa_window_decoder. It watches only the
// ports and relates them over time.
module isa_window_decoder_chk #(
    parameter int IA_W = 24,
    parameter int LA_W = 20,
    parameter int BE_N = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cyc_start,
    input logic            cyc_end,
    input logic [BE_N-1:0] host_be_n,
    input logic [IA_W-1:0] isa_addr,
    input logic            full_rd_n,
    input logic            full_wr_n,
    input logic            low_rd_n,
    input logic            low_wr_n,
    input logic            mem_sel,
    input logic            rom_sel,
    input logic            decode_miss
);
    logic quiet;
    logic idle;
    logic isa_on;

    // Derived views of the output bundle.
    always_comb begin
        quiet  = full_rd_n && full_wr_n && low_rd_n && low_wr_n;
        isa_on = !full_rd_n || !full_wr_n;
        idle   = quiet && !mem_sel && !rom_sel && !decode_miss && (isa_addr == '0);
    end

    a_r1_main_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel |-> (quiet && isa_addr == '0));

    a_r5_rom_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_sel || decode_miss) |-> (quiet && isa_addr == '0));

    a_r3_low_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        ((!low_rd_n |-> !full_rd_n) and (!low_wr_n |-> !full_wr_n)));

    a_r2_low_when_first_mb: assert property (@(posedge clk) disable iff (!rst_n)
        isa_on |-> ((low_rd_n && low_wr_n) == (isa_addr[IA_W-1:LA_W] != '0)));

    a_r6_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_sel, rom_sel, decode_miss, isa_on}));

    a_r12_dir_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!full_rd_n && !full_wr_n));

    a_r8_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && cyc_end) |=> idle);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !cyc_end) |=> $stable({isa_addr, full_rd_n, full_wr_n, low_rd_n,
                                          low_wr_n, mem_sel, rom_sel, decode_miss}));

    a_r10_no_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && cyc_start && (&host_be_n)) |=> idle);
endmodule

bind isa_window_decoder isa_window_decoder_chk #(.IA_W(IA_W), .LA_W(LA_W), .BE_N(BE_N)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_start   (cyc_start),
    .cyc_end     (cyc_end),
    .host_be_n   (host_be_n),
    .isa_addr    (isa_addr),
    .full_rd_n   (full_rd_n),
    .full_wr_n   (full_wr_n),
    .low_rd_n    (low_rd_n),
    .low_wr_n    (low_wr_n),
    .mem_sel     (mem_sel),
    .rom_sel     (rom_sel),
    .decode_miss (decode_miss)
);

// File: tb/isa_window_decoder_tb.sv
// Bench: table-driven decode checks, then directed protocol and reset cases.
module isa_window_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_start = 1'b0;
    logic        cyc_end = 1'b0;
    logic [31:3] host_addr = '0;
    logic [7:0]  host_be_n = 8'hFF;
    logic        host_wr = 1'b0;
    logic [23:0] isa_addr;
    logic        full_rd_n, full_wr_n, low_rd_n, low_wr_n;
    logic        mem_sel, rom_sel, decode_miss;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    isa_window_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_end(cyc_end),
        .host_addr(host_addr), .host_be_n(host_be_n), .host_wr(host_wr),
        .isa_addr(isa_addr), .full_rd_n(full_rd_n), .full_wr_n(full_wr_n),
        .low_rd_n(low_rd_n), .low_wr_n(low_wr_n), .mem_sel(mem_sel),
        .rom_sel(rom_sel), .decode_miss(decode_miss)
    );

    // Bench target codes: 0 memory, 1 ISA, 2 ROM, 3 miss.
    // Layout: addr[67:36] be_n[35:28] wr[27] tgt[26:25] isa_addr[24:1] low[0]
    localparam int NV = 16;
    localparam logic [67:0] VEC [NV] = '{
        {32'h0000_0000, 8'hFE, 1'b0, 2'd0, 24'h000000, 1'b0},  // R1
        {32'h0009_FFF8, 8'h7F, 1'b1, 2'd0, 24'h000000, 1'b0},  // R1
        {32'h0010_0000, 8'hFE, 1'b0, 2'd0, 24'h000000, 1'b0},  // R1
        {32'h07FF_FFF8, 8'hFE, 1'b1, 2'd0, 24'h000000, 1'b0},  // R1
        {32'h000A_0000, 8'hFE, 1'b0, 2'd1, 24'h0A0000, 1'b1},  // R2
        {32'h000F_FFF8, 8'h7F, 1'b1, 2'd1, 24'h0FFFFF, 1'b1},  // R2 R7
        {32'h000B_1230, 8'hE3, 1'b0, 2'd1, 24'h0B1232, 1'b1},  // R7
        {32'hFFF8_0000, 8'hFE, 1'b0, 2'd1, 24'hF80000, 1'b0},  // R3
        {32'hFFFD_FFF8, 8'h7F, 1'b1, 2'd1, 24'hFDFFFF, 1'b0},  // R3 R7
        {32'hFFFE_0000, 8'hFE, 1'b0, 2'd2, 24'h000000, 1'b0},  // R5
        {32'hFFFF_FFF8, 8'hFE, 1'b1, 2'd2, 24'h000000, 1'b0},  // R5
        {32'h0800_0000, 8'hFE, 1'b0, 2'd3, 24'h000000, 1'b0},  // R6
        {32'hFFF7_FFF8, 8'hFE, 1'b0, 2'd3, 24'h000000, 1'b0},  // R6
        {32'hFEF8_0000, 8'hFE, 1'b0, 2'd3, 24'h000000, 1'b0},  // R4
        {32'h7FF8_0000, 8'hFE, 1'b1, 2'd3, 24'h000000, 1'b0},  // R4
        {32'h00FA_0000, 8'hFE, 1'b0, 2'd0, 24'h000000, 1'b0}   // R4
    };

    localparam logic [30:0] IDLE = {24'h0, 4'b1111, 3'b000};

    function automatic logic [30:0] expect_out(logic [1:0] t, logic [23:0] a,
                                               logic lo, logic w);
        logic isa = (t == 2'd1);
        return {isa ? a : 24'h0, !(isa && !w), !(isa && w), !(isa && lo && !w),
                !(isa && lo && w), t == 2'd0, t == 2'd2, t == 2'd3};
    endfunction

    function automatic logic [30:0] observed();
        return {isa_addr, full_rd_n, full_wr_n, low_rd_n, low_wr_n,
                mem_sel, rom_sel, decode_miss};
    endfunction

    task automatic check(string req, logic [30:0] exp);
        logic [30:0] act = observed();
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic open_cycle(logic [31:0] a, logic [7:0] be, logic w);
        @(negedge clk);
        host_addr = a[31:3]; host_be_n = be; host_wr = w; cyc_start = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0;
    endtask

    task automatic close_cycle();
        cyc_end = 1'b1;
        @(negedge clk);
        cyc_end = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset idle", IDLE);
        rst_n = 1'b1;

        // Table walk: decode and release for every vector.
        for (int k = 0; k < NV; k++) begin
            open_cycle(VEC[k][67:36], VEC[k][35:28], VEC[k][27]);
            check($sformatf("R1-6/R7/R12 vector %0d", k),
                  expect_out(VEC[k][26:25], VEC[k][24:1], VEC[k][0], VEC[k][27]));
            close_cycle();
            check($sformatf("R8 release vector %0d", k), IDLE);
        end

        // R8: the result holds over idle cycles without an end pulse.
        open_cycle(32'h000C_0000, 8'hFB, 1'b1);
        repeat (3) @(negedge clk);
        check("R8 hold", expect_out(2'd1, 24'h0C0002, 1'b1, 1'b1));
        // R9: a second start while the cycle is open is ignored.
        open_cycle(32'h0010_0000, 8'hFE, 1'b0);
        check("R9 restart ignored", expect_out(2'd1, 24'h0C0002, 1'b1, 1'b1));
        close_cycle();
        check("R8 end", IDLE);

        // R10: no lanes enabled.
        open_cycle(32'h000A_0000, 8'hFF, 1'b0);
        check("R10 no lanes", IDLE);

        // R8: start and end at the same edge while idle opens the cycle.
        @(negedge clk);
        host_addr = 29'h1FFF_0000; host_be_n = 8'hBF; host_wr = 1'b0;
        cyc_start = 1'b1; cyc_end = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0; cyc_end = 1'b0;
        check("R8 start+end idle", expect_out(2'd1, 24'hF80006, 1'b0, 1'b0));
        close_cycle();

        // R11: reset in the middle of an open cycle.
        open_cycle(32'hFFFE_0000, 8'hFE, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 reset mid cycle", IDLE);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 after reset", IDLE);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end
endmodule